// File: doc/BRIEF.md
# Channel Buffer Pointer Tracker

This block follows the system-memory buffer that one logical channel of a serial media bus DMA engine is filling or draining. When software marks a next-buffer descriptor ready, the block loads a current pointer from its start field and a final pointer from its end field. It then steps the current pointer for each data quadlet that passes. It also forms the full 32-bit memory address by placing an upper half from one of eight base values above the current pointer.

A buffer closes once the current pointer has reached or passed the final pointer. Streaming channel types close on that quadlet. Packet channel types wait for the end of the packet, so on receive the pointer may run past the final address. When a buffer closes, the block pulses a done output and asks for the next descriptor. If none is ready, the channel stalls and flags starvation. In IO mode the two pointer registers hold one received 32-bit word instead, which is written directly by the data path.

Top module: `chan_buf_tracker`

## Requirements
- R1: After reset, `active`, `buf_done` and `starved` are 0, `cur_ptr` and `fin_ptr` are 0, and `nb_req` is 1 while `io_mode` is 0.
- R2: When `nb_req` and `nb_ready` are both 1 at a clock edge, the next cycle has `active`=1, `cur_ptr`=`nb_start` and `fin_ptr`=`nb_end`. For channel types 00 (synchronous), 10 (asynchronous) and 11 (control), bits [1:0] of both pointers are forced to 00. For type 01 (isochronous) all 16 bits are kept.
- R3: Each accepted beat (`beat_valid` while `beat_ready`) adds 4 to `cur_ptr` for types 00, 10 and 11. For type 01 it adds `beat_bytes`, which takes values 1 to 4.
- R4: For types 00 and 01, an accepted beat taken while `cur_ptr` >= `fin_ptr` closes the buffer. In the next cycle `active` is 0 and `buf_done` is 1.
- R5: For types 10 and 11, the buffer closes only on an accepted beat with `beat_last`=1 once `cur_ptr` >= `fin_ptr` has held at some accepted beat of that buffer. A packet end seen before that point does not close the buffer. Beats after that point let `cur_ptr` move beyond `fin_ptr` while `active` stays 1.
- R6: A packet-type buffer whose start equals its end closes at the end of its first packet.
- R7: `addr` = {`base_hi[{dir_tx, ch_type}]`, `cur_ptr`}. The array index is `dir_tx`*4 + `ch_type`, where `dir_tx`=0 means receive and 1 means transmit.
- R8: After the first buffer has been loaded, `starved`=1 and `beat_ready`=0 while no buffer is active, `io_mode` is 0 and `nb_ready` is 0. Beats offered in that state leave `cur_ptr` unchanged.
- R9: With `io_mode`=1, `nb_req` is 0 and no descriptor is loaded. On a receive channel (`dir_tx`=0), `io_wr` stores `io_data` so that `rx_data` = `io_data`, with `cur_ptr` holding bits [31:16] and `fin_ptr` holding bits [15:0]. On a transmit channel, `io_wr` leaves `rx_data` unchanged.
- R10: `buf_done` is high for exactly one cycle per closed buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_type | input | 2 | Channel type: 00 sync, 01 iso, 10 async, 11 control |
| dir_tx | input | 1 | 0 receive, 1 transmit |
| io_mode | input | 1 | Pointer registers act as a receive data word |
| base_hi | input | 8x16 | Upper address halves, indexed {dir_tx, ch_type} |
| nb_start | input | 16 | Next-buffer start address, low half |
| nb_end | input | 16 | Next-buffer end address, low half |
| nb_ready | input | 1 | Next-buffer descriptor is valid |
| nb_req | output | 1 | Tracker wants a next buffer |
| nb_take | output | 1 | Descriptor is consumed at this edge |
| beat_valid | input | 1 | One data quadlet moves this cycle |
| beat_bytes | input | 3 | Bytes in the beat (isochronous only, 1 to 4) |
| beat_last | input | 1 | Beat ends a packet |
| beat_ready | output | 1 | Channel can accept a beat |
| io_wr | input | 1 | Write of a received word in IO mode |
| io_data | input | 32 | Received word |
| active | output | 1 | A buffer is in progress |
| buf_done | output | 1 | One-cycle pulse when a buffer closes |
| starved | output | 1 | Channel stalled for lack of a next buffer |
| cur_ptr | output | 16 | Current address pointer, low half |
| fin_ptr | output | 16 | Final address pointer, low half |
| addr | output | 32 | Full memory address of the current quadlet |
| rx_data | output | 32 | IO-mode received word |

## Verification
The hardest case to reach from the ports is a packet-type receive buffer whose pointer has already passed its final address and must stay open. The reach is recorded only in an internal sticky state. The stimulus gets there by sending a packet end before the final address is reached, then several beats without a packet end that carry the pointer past the final address, and only then a packet end. The bench checks `active` and `cur_ptr` after each beat. A one-packet buffer with equal start and end exercises the same path from its first beat.

// File: rtl/chan_buf_tracker.sv
module chan_buf_tracker #(
  parameter int LO_W   = 16,
  parameter int NBASE  = 8,
  parameter int BYTE_W = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [1:0]                 ch_type,
  input  logic                       dir_tx,
  input  logic                       io_mode,
  input  logic [NBASE-1:0][LO_W-1:0] base_hi,
  input  logic [LO_W-1:0]            nb_start,
  input  logic [LO_W-1:0]            nb_end,
  input  logic                       nb_ready,
  output logic                       nb_req,
  output logic                       nb_take,
  input  logic                       beat_valid,
  input  logic [BYTE_W-1:0]          beat_bytes,
  input  logic                       beat_last,
  output logic                       beat_ready,
  input  logic                       io_wr,
  input  logic [2*LO_W-1:0]          io_data,
  output logic                       active,
  output logic                       buf_done,
  output logic                       starved,
  output logic [LO_W-1:0]            cur_ptr,
  output logic [LO_W-1:0]            fin_ptr,
  output logic [2*LO_W-1:0]          addr,
  output logic [2*LO_W-1:0]          rx_data
);

  localparam logic [1:0] T_ISO = 2'b01;
  localparam logic [LO_W-1:0] QUAD_MASK = {{(LO_W-2){1'b1}}, 2'b00};
  localparam logic [LO_W-1:0] QUAD_STEP = LO_W'(4);

  logic is_iso, is_pkt, take, hit, close, reached, ran, io_load;
  logic [LO_W-1:0] mask, step;

  assign is_iso     = (ch_type == T_ISO);
  assign is_pkt     = ch_type[1];
  assign mask       = is_iso ? '1 : QUAD_MASK;
  assign step       = is_iso ? LO_W'(beat_bytes) : QUAD_STEP;

  assign nb_req     = ~active & ~io_mode;
  assign nb_take    = nb_req & nb_ready;
  assign beat_ready = active & ~io_mode;
  assign take       = beat_ready & beat_valid;
  assign hit        = (cur_ptr >= fin_ptr);
  assign close      = take & (is_pkt ? (beat_last & (reached | hit)) : hit);
  assign starved    = ran & nb_req & ~nb_ready;
  assign io_load    = io_mode & io_wr & ~dir_tx;

  assign addr       = {base_hi[{dir_tx, ch_type}], cur_ptr};
  assign rx_data    = {cur_ptr, fin_ptr};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active   <= 1'b0;
      buf_done <= 1'b0;
      reached  <= 1'b0;
      ran      <= 1'b0;
      cur_ptr  <= '0;
      fin_ptr  <= '0;
    end else begin
      buf_done <= close;
      if (io_load) begin
        cur_ptr <= io_data[2*LO_W-1:LO_W];
        fin_ptr <= io_data[LO_W-1:0];
      end else if (nb_take) begin
        cur_ptr <= nb_start & mask;
        fin_ptr <= nb_end & mask;
        active  <= 1'b1;
        reached <= 1'b0;
        ran     <= 1'b1;
      end else if (take) begin
        cur_ptr <= cur_ptr + step;
        if (close) begin
          active  <= 1'b0;
          reached <= 1'b0;
        end else if (hit) begin
          reached <= 1'b1;
        end
      end
    end
  end

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_done |=> !buf_done);

  // R4
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_done |-> !active);

  // R3
  quad_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_ready && beat_valid && !is_iso) |=> (cur_ptr == $past(cur_ptr) + QUAD_STEP));

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (starved && beat_valid) |=> $stable(cur_ptr));

  // R2
  align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !io_mode && !is_iso) |-> (cur_ptr[1:0] == 2'b00 && fin_ptr[1:0] == 2'b00));

  // R9
  io_no_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_mode |-> !nb_take);

endmodule

// File: tb/tb_chan_buf_tracker.sv
module tb_chan_buf_tracker;
  logic clk = 0, rst_n = 0;
  logic [1:0] ch_type = 0;
  logic dir_tx = 0, io_mode = 0, nb_ready = 0, beat_valid = 0, beat_last = 0, io_wr = 0;
  logic [7:0][15:0] base_hi;
  logic [15:0] nb_start = 0, nb_end = 0;
  logic [2:0] beat_bytes = 0;
  logic [31:0] io_data = 0;
  logic nb_req, nb_take, beat_ready, active, buf_done, starved;
  logic [15:0] cur_ptr, fin_ptr;
  logic [31:0] addr, rx_data;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  chan_buf_tracker dut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic load(input logic [1:0] t, input logic d, input logic [15:0] s, input logic [15:0] e);
    ch_type = t; dir_tx = d; nb_start = s; nb_end = e; nb_ready = 1;
    tick();
    nb_ready = 0;
  endtask

  task automatic beat(input logic [2:0] b, input logic l);
    beat_valid = 1; beat_bytes = b; beat_last = l;
    tick();
    beat_valid = 0; beat_last = 0;
  endtask

  task automatic t_reset();
    chk(active == 0 && buf_done == 0 && starved == 0, "R1 flags", {active, buf_done, starved}, 0);
    chk(cur_ptr == 0 && fin_ptr == 0, "R1 pointers", {cur_ptr, fin_ptr}, 0);
    chk(nb_req == 1, "R1 nb_req", nb_req, 1);
  endtask

  task automatic t_sync();
    load(2'b00, 0, 16'h0102, 16'h010B);
    chk(active == 1, "R2 active", active, 1);
    chk(cur_ptr == 16'h0100 && fin_ptr == 16'h0108, "R2 aligned load", {cur_ptr, fin_ptr}, 32'h01000108);
    chk(addr == 32'hA0000100, "R7 sync rx addr", addr, 32'hA0000100);
    beat(0, 0);
    chk(cur_ptr == 16'h0104, "R3 step 4", cur_ptr, 16'h0104);
    beat(0, 0);
    chk(cur_ptr == 16'h0108 && active, "R3 step 4 again", cur_ptr, 16'h0108);
    beat(0, 0);
    chk(active == 0 && buf_done == 1, "R4 sync close", {active, buf_done}, 1);
    chk(cur_ptr == 16'h010C, "R3 last step", cur_ptr, 16'h010C);
    tick();
    chk(buf_done == 0, "R10 single pulse", buf_done, 0);
    chk(starved == 1 && beat_ready == 0, "R8 starved", {starved, beat_ready}, 2'b10);
    beat(0, 0);
    chk(cur_ptr == 16'h010C, "R8 beat ignored", cur_ptr, 16'h010C);
  endtask

  task automatic t_iso();
    load(2'b01, 1, 16'h0201, 16'h0206);
    chk(cur_ptr == 16'h0201 && fin_ptr == 16'h0206, "R2 iso unaligned", {cur_ptr, fin_ptr}, 32'h02010206);
    chk(addr == 32'hA0050201, "R7 iso tx addr", addr, 32'hA0050201);
    beat(3, 0);
    chk(cur_ptr == 16'h0204, "R3 iso 3 bytes", cur_ptr, 16'h0204);
    beat(2, 0);
    chk(cur_ptr == 16'h0206 && active, "R3 iso 2 bytes", cur_ptr, 16'h0206);
    beat(1, 0);
    chk(active == 0 && buf_done == 1 && cur_ptr == 16'h0207, "R4 iso close", {active, buf_done, cur_ptr}, 32'h00010207);
    tick();
  endtask

  task automatic t_async();
    load(2'b10, 0, 16'h0300, 16'h0304);
    chk(addr == 32'hA0020300, "R7 async rx addr", addr, 32'hA0020300);
    beat(0, 1);
    chk(active == 1 && cur_ptr == 16'h0304, "R5 early packet end ignored", {active, cur_ptr}, 32'h00010304);
    beat(0, 0);
    chk(active == 1 && cur_ptr == 16'h0308, "R5 reach no close", {active, cur_ptr}, 32'h00010308);
    beat(0, 0);
    chk(active == 1 && cur_ptr == 16'h030C, "R5 overrun allowed", {active, cur_ptr}, 32'h0001030C);
    beat(0, 1);
    chk(active == 0 && buf_done == 1, "R5 close at packet end", {active, buf_done}, 1);
    tick();
  endtask

  task automatic t_single();
    load(2'b11, 1, 16'h0400, 16'h0400);
    chk(addr == 32'hA0070400, "R7 ctrl tx addr", addr, 32'hA0070400);
    beat(0, 0);
    chk(active == 1 && cur_ptr == 16'h0404, "R6 open mid packet", {active, cur_ptr}, 32'h00010404);
    beat(0, 1);
    chk(active == 0 && buf_done == 1, "R6 single packet close", {active, buf_done}, 1);
    tick();
  endtask

  task automatic t_io();
    io_mode = 1; dir_tx = 0; ch_type = 2'b00; nb_ready = 1; nb_start = 16'h0500;
    #1;
    chk(nb_req == 0, "R9 no request", nb_req, 0);
    tick();
    chk(active == 0, "R9 no load", active, 0);
    io_wr = 1; io_data = 32'hDEADBEEF;
    tick();
    io_wr = 0;
    chk(rx_data == 32'hDEADBEEF && cur_ptr == 16'hDEAD, "R9 rx word", rx_data, 32'hDEADBEEF);
    dir_tx = 1; io_wr = 1; io_data = 32'h12345678;
    tick();
    io_wr = 0;
    chk(rx_data == 32'hDEADBEEF, "R9 tx write ignored", rx_data, 32'hDEADBEEF);
    io_mode = 0; nb_ready = 0;
    tick();
  endtask

  initial begin
    for (int i = 0; i < 8; i++) base_hi[i] = 16'hA000 + 16'(i);
    repeat (3) tick();
    t_reset();
    rst_n = 1;
    tick();
    t_sync();
    t_iso();
    t_async();
    t_single();
    t_io();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
    end
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule